// File: doc/BRIEF.md
# Coprocessor Stall Responder

This block answers a core's coprocessor handshake and holds the core off for a set number of cycles before it accepts an instruction. On every request strobe the core supplies a phase code: a plain continue, the first cycle of an instruction, a data-transfer beat, or an interrupt abort. It also supplies a free-running 32-bit cycle count. The block replies one clock later with a response code. The reply is one of four things: stall (BUSY), finished (DONE), restart as a fresh first cycle, or pass, which means the stall logic did not take the request and the rest of the coprocessor handles it.

A first-phase request that arrives while the block is idle records the current cycle count as a start time, stores the wait length and raises the internal busy flag. From then on each request is answered BUSY until the cycle count reaches start plus length. The next request after that point clears busy and is answered as a fresh first cycle, so the instruction starts again. An interrupt-phase request ends the wait at any moment and is answered DONE. The wait length is the configured count, plus one extra cycle when both the extended-interface flag and the extended-core flag are set. If the effective length is zero the stall logic is skipped completely. Typical per-unit settings are 0, 1 or 2 cycles.

Top module: `cp_stall_responder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy` and `rsp_valid` are 0 after that edge.
- R2: `rsp_valid` is 1 in exactly the cycle after a clock edge that sampled `req_valid` high. Otherwise it is 0. `rsp_code` belongs to that request.
- R3: Phase codes are CONT=0, FIRST=1, XFER=2, INTR=3. Response codes are PASS=0, BUSY=1, DONE=2, FIRST=3. With a nonzero effective length, an INTR request is answered DONE and leaves `busy` at 0, whether or not a wait was running.
- R4: With a nonzero effective length, a FIRST request while not busy is answered BUSY and sets `busy`. The sampled `cycle_now` becomes the start time.
- R5: While busy, a non-INTR request sampled with `cycle_now` < start + length is answered BUSY and `busy` stays 1.
- R6: While busy, a non-INTR request sampled with `cycle_now` >= start + length is answered FIRST and clears `busy`.
- R7: The effective length is `wait_cfg` + 1 when `ext_iface` and `ext_core` are both 1. Otherwise it is `wait_cfg`.
- R8: With an effective length of zero, every request is answered PASS and `busy` does not change.
- R9: With a nonzero effective length, a CONT or XFER request while not busy is answered PASS and leaves `busy` at 0.
- R10: The length is captured when the wait starts. Changes to `wait_cfg` or to the mode flags during the wait do not move the expiry point, as long as the effective length stays nonzero. Without a request, `busy` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe from the core |
| req_phase | input | 2 | Phase code of the request |
| cycle_now | input | 32 | Free-running cycle count |
| wait_cfg | input | WAIT_W (4) | Configured wait count |
| ext_iface | input | 1 | Extended-interface mode |
| ext_core | input | 1 | Extended-core flag |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_code | output | 2 | Response code |
| busy | output | 1 | A wait is in progress |

## Verification
The bench sweeps every combination of configured count 0 to 3, both mode flags and request spacings of 0 to 2 idle cycles. It therefore reaches the exact expiry cycle from several directions. An off-by-one in the compare would answer BUSY one request too many or release one too early. A design that got the extension rule wrong would release at the plain count when both flags are set. Interrupts are sent both in the middle of a wait and while idle. A design that only handled them when busy would answer PASS instead of DONE. The wait count is also changed during a wait. A design that compared against the live configuration would move the release point. The zero-length case is checked with INTR as well, because bypass must answer PASS even for an abort.

// File: rtl/cpbw_pkg.sv
// Shared phase and response encodings for the stall responder.
// Assumes a two-bit phase and a two-bit response field at the top ports.
package cpbw_pkg;
    typedef enum logic [1:0] {
        PH_CONT  = 2'd0,
        PH_FIRST = 2'd1,
        PH_XFER  = 2'd2,
        PH_INTR  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        RS_PASS  = 2'd0,
        RS_BUSY  = 2'd1,
        RS_DONE  = 2'd2,
        RS_FIRST = 2'd3
    } resp_e;
endpackage

// File: rtl/cpbw_duration.sv
// Works out the effective wait length from the configured count and the two
// mode flags. Adds one cycle only when both flags are set.
// Assumes: purely combinational, and the output is one bit wider than the input.
module cpbw_duration #(
    parameter int WAIT_W = 4,
    localparam int DUR_W = WAIT_W + 1
) (
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              ext_iface,
    input  logic              ext_core,
    output logic [DUR_W-1:0]  dur_eff,
    output logic              active
);
    logic extra;

    // Combine the configured count with the extension rule.
    always_comb begin
        extra   = ext_iface & ext_core;
        dur_eff = {1'b0, wait_cfg} + {{(DUR_W-1){1'b0}}, extra};
        active  = (dur_eff != '0);
    end
endmodule

// File: rtl/cpbw_timer.sv
// Holds the start timestamp and the length of the current wait, and reports
// whether the live cycle count has reached their sum.
// Assumes: unsigned compare with no wrap of the cycle count during a wait.
module cpbw_timer #(
    parameter int TIME_W = 32,
    parameter int DUR_W  = 5,
    localparam int SUM_W = TIME_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] start_in,
    input  logic [DUR_W-1:0]  dur_in,
    input  logic [TIME_W-1:0] now,
    output logic              expired
);
    logic [TIME_W-1:0] start_q;
    logic [DUR_W-1:0]  dur_q;
    logic [SUM_W-1:0]  end_time;

    // Capture start time and length when a wait begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            dur_q   <= '0;
        end else if (load) begin
            start_q <= start_in;
            dur_q   <= dur_in;
        end
    end

    // Compare the live count with the stored end point.
    always_comb begin
        end_time = {1'b0, start_q} + {{(SUM_W-DUR_W){1'b0}}, dur_q};
        expired  = ({1'b0, now} >= end_time);
    end
endmodule

// File: rtl/cpbw_ctrl.sv
// Decides the response for each request and keeps the busy flag. The response
// is registered and valid one cycle after the strobe.
// Assumes: 'expired' and 'active' are valid in the cycle of the request.
module cpbw_ctrl
    import cpbw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_phase,
    input  logic       active,
    input  logic       expired,
    output logic       load,
    output logic       busy,
    output logic       rsp_valid,
    output logic [1:0] rsp_code
);
    logic  busy_n;
    resp_e code_n;
    phase_e ph;

    // Pick the next busy state and the response for the present request.
    always_comb begin
        ph     = phase_e'(req_phase);
        busy_n = busy;
        code_n = RS_PASS;
        load   = 1'b0;
        if (req_valid && active) begin
            if (ph == PH_INTR) begin
                busy_n = 1'b0;
                code_n = RS_DONE;
            end else if (busy) begin
                if (expired) begin
                    busy_n = 1'b0;
                    code_n = RS_FIRST;
                end else begin
                    code_n = RS_BUSY;
                end
            end else if (ph == PH_FIRST) begin
                load   = 1'b1;
                busy_n = 1'b1;
                code_n = RS_BUSY;
            end
        end
    end

    // Register busy flag and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_code  <= RS_PASS;
        end else begin
            busy      <= busy_n;
            rsp_valid <= req_valid;
            rsp_code  <= req_valid ? code_n : RS_PASS;
        end
    end

    // R3
    intr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && active && req_phase == PH_INTR) |=> (rsp_code == RS_DONE && !busy));
    // R4
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && req_phase == PH_FIRST && active));
    // R2
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && active && req_phase != PH_INTR && !expired)
        |=> (busy && rsp_code == RS_BUSY));
    // R6
    expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && active && req_phase != PH_INTR && expired)
        |=> (!busy && rsp_code == RS_FIRST));
endmodule

// File: rtl/cp_stall_responder.sv
// Top level of the coprocessor stall responder: effective-length logic, wait
// timer and response control.
// Assumes: cycle_now does not wrap during a wait; synchronous active-low reset.
module cp_stall_responder
    import cpbw_pkg::*;
#(
    parameter int WAIT_W = 4,
    parameter int TIME_W = 32,
    localparam int DUR_W = WAIT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_phase,
    input  logic [TIME_W-1:0] cycle_now,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              ext_iface,
    input  logic              ext_core,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              busy
);
    logic [DUR_W-1:0] dur_eff;
    logic             active;
    logic             expired;
    logic             load;

    cpbw_duration #(.WAIT_W(WAIT_W)) dur_i (
        .wait_cfg (wait_cfg),
        .ext_iface(ext_iface),
        .ext_core (ext_core),
        .dur_eff  (dur_eff),
        .active   (active)
    );

    cpbw_timer #(.TIME_W(TIME_W), .DUR_W(DUR_W)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .start_in(cycle_now),
        .dur_in  (dur_eff),
        .now     (cycle_now),
        .expired (expired)
    );

    cpbw_ctrl ctl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_phase(req_phase),
        .active   (active),
        .expired  (expired),
        .load     (load),
        .busy     (busy),
        .rsp_valid(rsp_valid),
        .rsp_code (rsp_code)
    );

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(busy));
    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !active) |=> (rsp_code == RS_PASS && $stable(busy)));
endmodule

// File: tb/cp_stall_responder_tb.sv
module cp_stall_responder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_phase = 2'd0;
    logic [31:0] cycle_now = 32'd0;
    logic [3:0]  wait_cfg = 4'd1;
    logic        ext_iface = 1'b0;
    logic        ext_core = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic        busy;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // bench reference state
    bit          m_busy = 0;
    logic [32:0] m_end = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycle_now <= cycle_now + 32'd1;

    cp_stall_responder dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_phase(req_phase),
        .cycle_now(cycle_now), .wait_cfg(wait_cfg), .ext_iface(ext_iface),
        .ext_core(ext_core), .rsp_valid(rsp_valid), .rsp_code(rsp_code), .busy(busy)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge: issue one request and check its reply.
    task automatic send(logic [1:0] ph);
        int d;
        logic [1:0] ecode;
        string tag;
        d = int'(wait_cfg) + ((ext_iface && ext_core) ? 1 : 0);
        if (d == 0) begin
            ecode = 2'd0; tag = "R8";
        end else if (ph == 2'd3) begin
            ecode = 2'd2; m_busy = 0; tag = "R3";
        end else if (m_busy) begin
            if ({1'b0, cycle_now} < m_end) begin
                ecode = 2'd1; tag = "R5";
            end else begin
                ecode = 2'd3; m_busy = 0; tag = "R6";
            end
        end else if (ph == 2'd1) begin
            ecode = 2'd1; m_busy = 1;
            m_end = {1'b0, cycle_now} + 33'(d);
            tag = (ext_iface && ext_core) ? "R7" : "R4";
        end else begin
            ecode = 2'd0; tag = "R9";
        end
        req_valid = 1'b1;
        req_phase = ph;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R2 valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " code"}, 32'(rsp_code), 32'(ecode));
        chk({tag, " busy"}, 32'(busy), 32'(m_busy));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R2 no valid", 32'(rsp_valid), 32'd0);
            chk("R10 busy idle", 32'(busy), 32'(m_busy));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 valid", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep counts, flags and spacing
        for (int c = 0; c < 4; c++)
            for (int f = 0; f < 4; f++)
                for (int g = 0; g < 3; g++) begin
                    wait_cfg = 4'(c);
                    ext_iface = f[0];
                    ext_core = f[1];
                    send(2'd1);
                    for (int k = 0; k < 8 && m_busy; k++) begin
                        idle(g);
                        send((k % 2 == 0) ? 2'd0 : 2'd2);
                    end
                    send(2'd2);
                    send(2'd3);
                    idle(1);
                end

        // interrupt in the middle of a wait
        wait_cfg = 4'd3; ext_iface = 0; ext_core = 0;
        send(2'd1);
        send(2'd0);
        send(2'd3);
        send(2'd0);
        send(2'd3);

        // configuration change during a wait must not move expiry (R10)
        wait_cfg = 4'd2;
        send(2'd1);
        wait_cfg = 4'd6;
        ext_iface = 1; ext_core = 1;
        send(2'd0);
        send(2'd0);
        send(2'd0);
        ext_iface = 0; ext_core = 0;

        // flags alone give no extra cycle (R7)
        wait_cfg = 4'd1; ext_iface = 1;
        send(2'd1);
        send(2'd0);
        ext_iface = 0; ext_core = 1;
        send(2'd1);
        send(2'd0);
        ext_core = 0;

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule